// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns one parallel byte into an asynchronous serial frame on a single output line. A six-bit format word, which may change at run time, sets the frame shape. It selects 5 to 8 data bits, an optional parity bit that is odd, even or fixed, and a stop period of one, one and a half or two bit times. The line rests high. A frame starts with one low start bit, then carries the data bits least significant first, then the parity bit if parity is enabled, then the stop period at the high level.

Bit timing comes from a 16x oversampling tick. The tick is a one-cycle clock enable from a baud generator outside the block, and each bit lasts 16 ticks. A one-entry holding register sits in front of the shift engine. A writer may queue the next byte while the current frame is still going out, and the ready flag tells it when that entry is free. The format word is captured when a frame starts.

Top module: `fmt_async_tx`

## Requirements
- R1: After reset, `txd_o` is high and `ready_o` is high. `txd_o` stays high whenever no frame is in progress.
- R2: A byte written while `ready_o` is high moves to the shift engine on the next clock edge if that engine is idle. From that edge `txd_o` is low for 16 ticks, which is the start bit.
- R3: `fmt_i[1:0]` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. The data bits follow the start bit least significant first, 16 ticks each. Data bits above the selected length are not sent.
- R4: With `fmt_i[3]` = 1, one parity bit of 16 ticks follows the last data bit. With `fmt_i[3]` = 0, no parity bit is sent.
- R5: With parity on and `fmt_i[5]` = 0, `fmt_i[4]` = 0 makes the number of ones in the sent data bits plus the parity bit odd, and `fmt_i[4]` = 1 makes it even.
- R6: With parity on and `fmt_i[5]` = 1, the parity bit is a constant: 1 when `fmt_i[4]` = 0 and 0 when `fmt_i[4]` = 1.
- R7: The stop period is high. It lasts 16 ticks when `fmt_i[2]` = 0. When `fmt_i[2]` = 1 it lasts 24 ticks for 5 data bits and 32 ticks for 6, 7 or 8 data bits. The next frame cannot start before the stop period has ended.
- R8: `ready_o` falls after an accepted write and stays low until the held byte moves to the shift engine. A write made while `ready_o` is low is ignored and never appears on the line.
- R9: The format is captured at the clock edge where a frame starts. Changes to `fmt_i` during a frame do not affect that frame.
- R10: During a frame, `txd_o` changes only on clock edges where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-cycle enable at 16 times the bit rate |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to transmit |
| fmt_i | input | 6 | Frame format word: [1:0] length, [2] long stop, [3] parity on, [4] even/constant-0, [5] constant parity |
| txd_o | output | 1 | Serial line, high when idle |
| ready_o | output | 1 | High while the holding register is empty |

## Verification
The assertions check the line-level rules on every cycle. The line is high whenever no frame is in progress and at the end of each frame, and it is low on the edge where a frame starts. The line does not move between ticks. The ready flag falls only after a write and stays low while the shift engine is busy. The exact bit sequence, the parity value for each format and the 16, 24 and 32 tick stop lengths can only be shown by the bench scenarios. There, a behavioural model builds each frame as a list of line levels per tick and is compared with the outputs on every clock. The same model shows that a write to a full holding register is dropped and that a format change in the middle of a frame has no effect on it.

// File: rtl/fmt_tx_pkg.sv
package fmt_tx_pkg;

  // Layout of the format word; bit positions are decoded by the framer.
  typedef struct packed {
    logic       par_stick; // [5] constant parity value
    logic       par_even;  // [4] even parity / constant 0
    logic       par_en;    // [3] parity bit present
    logic       stop_long; // [2] long stop period
    logic [1:0] wlen;      // [1:0] data length minus five
  } line_fmt_t;

  localparam int unsigned FMT_W = $bits(line_fmt_t);

endpackage

// File: rtl/fmt_tx_hold.sv
module fmt_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (take_i) begin
      full_d = 1'b0;
    end else if (wr_i && !full_q) begin
      full_d = 1'b1;
      data_d = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

endmodule

// File: rtl/fmt_tx_framer.sv
module fmt_tx_framer
  import fmt_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OS      = 16,
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned CNT_W   = 8
) (
  input  logic [DATA_W-1:0]  data_i,
  input  line_fmt_t          fmt_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   last_o
);

  localparam int unsigned WL_BASE = DATA_W - 3;

  int unsigned       nbits;
  int unsigned       stop_ticks;
  int unsigned       total;
  logic [DATA_W-1:0] keep;
  logic              par_bit;

  always_comb begin
    nbits = WL_BASE + int'(fmt_i.wlen);
    for (int unsigned i = 0; i < DATA_W; i++) begin
      keep[i] = (i < nbits);
    end

    if (fmt_i.par_stick)     par_bit = ~fmt_i.par_even;
    else if (fmt_i.par_even) par_bit = ^(data_i & keep);
    else                     par_bit = ~^(data_i & keep);

    // Levels per bit slot: start, data, optional parity; unused slots stay high.
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      if (i < nbits) frame_o[i+1] = data_i[i];
    end
    for (int unsigned i = 1; i < FRAME_W; i++) begin
      if (fmt_i.par_en && (i == nbits + 1)) frame_o[i] = par_bit;
    end

    if (!fmt_i.stop_long)       stop_ticks = OS;
    else if (fmt_i.wlen == 2'b00) stop_ticks = OS + OS / 2;
    else                        stop_ticks = 2 * OS;

    total  = OS * (1 + nbits + int'(fmt_i.par_en)) + stop_ticks;
    last_o = CNT_W'(total - 1);
  end

endmodule

// File: rtl/fmt_tx_serializer.sv
module fmt_tx_serializer #(
  parameter int unsigned OS      = 16,
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned CNT_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               avail_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   last_i,
  output logic               take_o,
  output logic               busy_o,
  output logic               txd_o
);

  localparam int unsigned IDX_W = $clog2(FRAME_W);

  logic               busy_q, busy_d;
  logic               txd_q, txd_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   last_q, last_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [CNT_W-1:0]   cnt_inc;
  logic [IDX_W-1:0]   idx_next;

  assign cnt_inc  = cnt_q + 1'b1;
  assign idx_next = IDX_W'(cnt_inc / CNT_W'(OS));
  assign take_o   = !busy_q && avail_i;

  always_comb begin
    busy_d  = busy_q;
    txd_d   = txd_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    frame_d = frame_q;
    if (!busy_q) begin
      if (avail_i) begin
        busy_d  = 1'b1;
        cnt_d   = '0;
        frame_d = frame_i;
        last_d  = last_i;
        txd_d   = frame_i[0];
      end
    end else if (tick_i) begin
      if (cnt_q == last_q) begin
        busy_d = 1'b0;
        txd_d  = 1'b1;
      end else begin
        cnt_d = cnt_inc;
        txd_d = (32'(idx_next) < FRAME_W) ? frame_q[idx_next] : 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
      cnt_q   <= '0;
      last_q  <= '0;
      frame_q <= '1;
    end else begin
      busy_q  <= busy_d;
      txd_q   <= txd_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      frame_q <= frame_d;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = txd_q;

endmodule

// File: rtl/fmt_async_tx.sv
module fmt_async_tx
  import fmt_tx_pkg::*;
#(
  parameter int unsigned OS     = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [FMT_W-1:0]  fmt_i,
  output logic              txd_o,
  output logic              ready_o
);

  localparam int unsigned FRAME_W = DATA_W + 4;
  localparam int unsigned CNT_W   = $clog2(FRAME_W * OS + 1);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               hold_full;
  logic [DATA_W-1:0]  hold_data;
  logic               take;
  logic               ser_busy;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   last_tick;
  line_fmt_t          fmt;

  // Assert asynchronously, release after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign fmt = line_fmt_t'(fmt_i);

  fmt_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .wr_i   (wr_i),
    .data_i (wr_data_i),
    .take_i (take),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  fmt_tx_framer #(
    .DATA_W (DATA_W),
    .OS     (OS),
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_framer (
    .data_i (hold_data),
    .fmt_i  (fmt),
    .frame_o(frame),
    .last_o (last_tick)
  );

  fmt_tx_serializer #(
    .OS     (OS),
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .tick_i (tick_i),
    .avail_i(hold_full),
    .frame_i(frame),
    .last_i (last_tick),
    .take_o (take),
    .busy_o (ser_busy),
    .txd_o  (txd_o)
  );

  assign ready_o = !hold_full;

endmodule

// File: rtl/fmt_async_tx_chk.sv
module fmt_async_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic wr_i,
  input logic txd_o,
  input logic ready_o,
  input logic busy
);

  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> txd_o);

  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !txd_o);

  a_r7_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> txd_o);

  a_r8_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && busy) |=> !ready_o);

  a_r8_fill_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(wr_i));

  a_r10_stable_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !tick_i) |=> $stable(txd_o));

endmodule

bind fmt_async_tx fmt_async_tx_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .wr_i   (wr_i),
  .txd_o  (txd_o),
  .ready_o(ready_o),
  .busy   (ser_busy)
);

// File: tb/fmt_async_tx_test.sv
module fmt_async_tx_test;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       wr;
  logic [7:0] wdata;
  logic [5:0] fmt;
  logic       txd;
  logic       ready;

  int    tests = 0;
  int    fails = 0;
  int    tdiv  = 2;
  int    tcnt  = 0;
  string cur_req = "R1";

  // reference model state
  bit m_full;
  int m_data;
  bit m_busy;
  bit m_txd = 1'b1;
  bit q[$];
  int rel;

  fmt_async_tx uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .wr_i     (wr),
    .wr_data_i(wdata),
    .fmt_i    (fmt),
    .txd_o    (txd),
    .ready_o  (ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tcnt++;
      if (tcnt >= tdiv) tcnt = 0;
      tick = (tcnt == 0);
    end
  end

  // Level per tick for one frame, from the requirements.
  function automatic void build(int d, bit [5:0] f);
    int n;
    int ones;
    int st;
    bit par;
    bit lv[$];
    n    = 5 + int'(f[1:0]);
    ones = 0;
    q.delete();
    lv.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      lv.push_back(d[i]);
      ones += d[i];
    end
    if (f[3]) begin
      if (f[5])      par = !f[4];
      else if (f[4]) par = (ones % 2) == 1;
      else           par = (ones % 2) == 0;
      lv.push_back(par);
    end
    foreach (lv[k]) for (int j = 0; j < 16; j++) q.push_back(lv[k]);
    if (!f[2])       st = 16;
    else if (n == 5) st = 24;
    else             st = 32;
    for (int j = 0; j < st; j++) q.push_back(1'b1);
  endfunction

  always @(posedge clk) begin
    bit was_full;
    bit was_busy;
    if (!rst_n || rel < 2) begin
      rel    = rst_n ? rel + 1 : 0;
      m_full = 0;
      m_busy = 0;
      m_txd  = 1;
      q.delete();
    end else begin
      was_full = m_full;
      was_busy = m_busy;
      if (!was_busy) begin
        if (was_full) begin
          build(m_data, fmt);
          m_busy = 1;
          m_txd  = q[0];
          m_full = 0;
        end
      end else if (tick) begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          m_busy = 0;
          m_txd  = 1;
        end else begin
          m_txd = q[0];
        end
      end
      if (wr && !was_full) begin
        m_full = 1;
        m_data = int'(wdata);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk({cur_req, " line"}, int'(txd), int'(m_txd));
        chk({cur_req, " ready"}, int'(ready), int'(!m_full));
      end
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic put(bit [7:0] d, bit [5:0] f);
    while (!ready) @(negedge clk);
    fmt   = f;
    wdata = d;
    wr    = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk("R8 ready low after write", int'(ready), 0);
  endtask

  task automatic drain();
    do @(negedge clk); while (m_busy || m_full);
    chk("R1 idle line high", int'(txd), 1);
  endtask

  task automatic send(bit [7:0] d, bit [5:0] f, string req);
    cur_req = req;
    put(d, f);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    rst_n = 1'b0;
    wr    = 1'b0;
    wdata = 8'h00;
    fmt   = 6'b000000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset line", int'(txd), 1);
    chk("R1 reset ready", int'(ready), 1);

    // R2 R3: word lengths
    send(8'hA5, 6'b000000, "R2");
    send(8'hFF, 6'b000001, "R3 six bits");
    send(8'h96, 6'b000010, "R3 seven bits");
    send(8'h3C, 6'b000011, "R3 eight bits");
    // R4 R5 R6: parity
    send(8'h00, 6'b000000, "R4 no parity");
    send(8'h07, 6'b001011, "R5 odd parity");
    send(8'h07, 6'b011011, "R5 even parity");
    send(8'h1E, 6'b001000, "R5 odd five bits");
    send(8'h55, 6'b101011, "R6 stick one");
    send(8'h55, 6'b111011, "R6 stick zero");
    // R7: stop lengths
    send(8'h12, 6'b000100, "R7 one and a half");
    send(8'h34, 6'b000111, "R7 two stop");
    send(8'h34, 6'b001110, "R7 two stop parity");

    // R8: queue one, then a write on a full register is dropped
    cur_req = "R8";
    put(8'h11, 6'b000011);
    repeat (3) @(negedge clk);
    put(8'h22, 6'b000011);
    wdata = 8'h33;
    wr    = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk("R8 ignored write keeps ready low", int'(ready), 0);
    drain();

    // R9: format change in mid frame
    cur_req = "R9";
    put(8'h5A, 6'b000011);
    repeat (60) @(negedge clk);
    fmt = 6'b111100;
    drain();

    // R10: different tick rates
    tdiv = 1;
    send(8'hC3, 6'b011111, "R10 tick every cycle");
    tdiv = 3;
    send(8'h6D, 6'b001101, "R10 tick every third");

    repeat (5) @(negedge clk);
    report();
  end

endmodule